// File: doc/BRIEF.md
# Rectangular Pulse Generator with Two Compare Points

This block produces a periodic rectangular waveform from a counter that runs freely while enabled. Two compare values are programmed at the inputs. When the counter reaches the first value, the output goes high. When the counter reaches the second value, the output goes low and the counter restarts from zero. The second value therefore sets the period, and the distance between the two values sets how long the output stays high.

A single-bit state machine holds the waveform level, and its state bit is the output. Each compare hit is also reported as a one-cycle pulse. The enable input is passed straight through to its own output so that downstream logic, such as a limit checker, can tell whether the generator is meant to be running.

The compare values are copied into shadow registers at the wrap point, and also at every cycle while the block is disabled. Because of this, new values written in the middle of a period take effect only from the next period onward.

Top module: `pg_rect_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `wave_o`, `match1_o` and `match2_o` are 0 until the block is enabled.
- R2: While `en` is high, `match1_o` is 1 in exactly the cycles where the counter equals the active first compare value, and `match2_o` is 1 in exactly the cycles where it equals the active second compare value. The counter starts at 0 in the first enabled cycle.
- R3: After the cycle in which `match2_o` is 1, the counter returns to 0. Otherwise it increments by 1 each enabled cycle, so the period is the second compare value plus one cycles.
- R4: `wave_o` becomes 1 on the clock edge that ends a cycle with `match1_o` set and `match2_o` clear. It becomes 0 on the edge that ends a cycle with `match2_o` set. When first < second, it is high for (second − first) cycles of each period.
- R5: When the first compare value is greater than or equal to the second, `wave_o` stays 0 for the whole period.
- R6: While `en` is low, the match outputs are 0, the counter is held at 0, and `wave_o` is 0 from the next clock edge on.
- R7: `en_fwd_o` always equals `en`.
- R8: Compare inputs are taken into the active values only on the edge that ends a `match2_o` cycle, or on any edge while `en` is low. A change made mid-period does not alter the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for waveform generation |
| cmp1_i | input | CNT_W | Compare value at which the output goes high |
| cmp2_i | input | CNT_W | Compare value at which the output goes low and the counter wraps |
| wave_o | output | 1 | Rectangular waveform |
| en_fwd_o | output | 1 | Copy of `en` for downstream logic |
| match1_o | output | 1 | One-cycle pulse on a first-compare hit |
| match2_o | output | 1 | One-cycle pulse on a second-compare hit |

## Verification
The waveform is tried with compare pairs of three kinds. Ordinary pairs show whether the high time tracks the difference of the two values. Pairs that are equal or inverted show whether the clear action wins over the set action. A pair of zeros gives a one-cycle period and exposes off-by-one errors in the wrap. A pair with the first value at zero shows whether the rise happens in the very first period. A mid-period rewrite of the compare inputs separates shadowed loading from direct use of the inputs. Dropping `en` in the middle of a high phase shows whether the level and the counter are both cleared.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    WAVE_LOW  = 1'b0,
    WAVE_HIGH = 1'b1
  } wave_state_e;
endpackage

// File: rtl/pg_counter.sv
module pg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  output logic             hit1_o,
  output logic             hit2_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act1_q, act1_d;
  logic [CNT_W-1:0] act2_q, act2_d;
  logic             reload;

  assign hit1_o = en && (cnt_q == act1_q);
  assign hit2_o = en && (cnt_q == act2_q);
  assign reload = !en || hit2_o;

  always_comb begin
    cnt_d  = cnt_q;
    act1_d = act1_q;
    act2_d = act2_q;
    if (!en || hit2_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
    if (reload) begin
      act1_d = cmp1_i;
      act2_d = cmp2_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act1_q <= '0;
      act2_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      act1_q <= act1_d;
      act2_q <= act2_d;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit2_o |=> (cnt_q == '0)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit2_o) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R3
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R6
  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit2_o) |=> ($stable(act1_q) && $stable(act2_q))); // R8
endmodule

// File: rtl/pg_wave_fsm.sv
module pg_wave_fsm
  import pg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit1_i,
  input  logic hit2_i,
  output logic wave_o
);
  wave_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en || hit2_i) begin
      state_d = WAVE_LOW;
    end else if (hit1_i) begin
      state_d = WAVE_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WAVE_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  assign wave_o = (state_q == WAVE_HIGH);

  AST_RISE_ON_HIT1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_o) |-> ($past(hit1_i) && !$past(hit2_i))); // R4
  AST_FALL_ON_HIT2: assert property (@(posedge clk) disable iff (!rst_n)
    hit2_i |=> !wave_o); // R5
  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wave_o); // R6
endmodule

// File: rtl/pg_rect_gen.sv
module pg_rect_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  output logic             wave_o,
  output logic             en_fwd_o,
  output logic             match1_o,
  output logic             match2_o
);
  logic hit1, hit2;

  pg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .cmp1_i (cmp1_i),
    .cmp2_i (cmp2_i),
    .hit1_o (hit1),
    .hit2_o (hit2)
  );

  pg_wave_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .hit1_i (hit1),
    .hit2_i (hit2),
    .wave_o (wave_o)
  );

  assign match1_o = hit1;
  assign match2_o = hit2;
  assign en_fwd_o = en;

  AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!match1_o && !match2_o)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!wave_o && !match1_o && !match2_o)); // R1
endmodule

// File: tb/pg_rect_gen_tb.sv
module pg_rect_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NVEC = 6;
  // {cmp1, cmp2, cycles to run}
  localparam int VEC [NVEC][3] = '{
    '{2, 9, 25}, '{0, 5, 15}, '{4, 4, 12}, '{7, 3, 10}, '{0, 0, 5}, '{1, 2, 9}
  };

  logic clk = 1'b0;
  logic rst_n, en;
  logic [CNT_W-1:0] cmp1, cmp2;
  logic wave, en_fwd, m1, m2;

  int errors = 0;
  int checks = 0;
  int ph, act1, act2;
  logic wexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_rect_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp1_i(cmp1), .cmp2_i(cmp2),
    .wave_o(wave), .en_fwd_o(en_fwd), .match1_o(m1), .match2_o(m2)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {wave,en_fwd,m1,m2} actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Called just after a negedge: checks outputs, then advances the model
  // over the coming posedge using the inputs as they stand.
  task automatic step(input string tag);
    logic e1, e2;
    e1 = en && (ph == act1);
    e2 = en && (ph == act2);
    #1;
    check(tag, {wave, en_fwd, m1, m2}, {wexp, en, e1, e2});
    if (!en) begin
      ph = 0; act1 = int'(cmp1); act2 = int'(cmp2); wexp = 1'b0;
    end else begin
      if (e2) wexp = 1'b0;
      else if (e1) wexp = 1'b1;
      if (e2) begin
        ph = 0; act1 = int'(cmp1); act2 = int'(cmp2);
      end else begin
        ph++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; cmp1 = 16'd3; cmp2 = 16'd6;
    ph = 0; act1 = 3; act2 = 6; wexp = 1'b0;
    repeat (2) @(negedge clk);
    #1 check("R1 in reset", {wave, en_fwd, m1, m2}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 after release");
    step("R7 disabled");

    // Table walk: R2 R3 R4 R5 across compare pairs
    for (int v = 0; v < NVEC; v++) begin
      en = 1'b0; cmp1 = CNT_W'(VEC[v][0]); cmp2 = CNT_W'(VEC[v][1]);
      step("R6 idle between vectors");
      en = 1'b1;
      for (int c = 0; c < VEC[v][2]; c++) begin
        if (VEC[v][0] >= VEC[v][1]) step("R5 low when cmp1>=cmp2");
        else step("R2 R3 R4 waveform");
      end
    end

    // R8: rewrite compares mid-period, old period must finish unchanged
    en = 1'b0; cmp1 = 16'd2; cmp2 = 16'd9;
    step("R6 idle");
    en = 1'b1;
    for (int c = 0; c < 4; c++) step("R8 before rewrite");
    cmp1 = 16'd1; cmp2 = 16'd4;
    for (int c = 0; c < 20; c++) step("R8 shadow reload");

    // R6: drop enable during high phase, then restart from zero
    en = 1'b0; cmp1 = 16'd1; cmp2 = 16'd8;
    step("R6 idle");
    en = 1'b1;
    for (int c = 0; c < 4; c++) step("R4 rising");
    if (wave !== 1'b1) begin
      errors++;
      $display("FAIL R4 wave actual=%b expected=1 before disable", wave);
    end
    checks++;
    en = 1'b0;
    for (int c = 0; c < 3; c++) step("R6 disable mid-high");
    en = 1'b1;
    for (int c = 0; c < 12; c++) step("R6 restart from zero");

    // R7: enable forwarding toggles
    en = 1'b0; step("R7 fwd low");
    en = 1'b1; step("R7 fwd high");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule